// File: doc/BRIEF.md
# DMA Address Watermark Interrupt Unit

This unit watches the addresses that a DMA engine issues while it streams an audio buffer. Software programs up to four watermark addresses. When the engine presents one of those addresses with its address-valid strobe high, the matching level records the event in a sticky flag. Software enables each level separately. The unit drives one combined interrupt line, which is high while any enabled level has its flag set.

Software reaches the unit through a generic single-cycle register port. Index 0 selects the control/status word. Indexes 1 to 4 select the watermark addresses of levels 0 to 3. Writes take effect on the clock edge at which `reg_en` and `reg_we` are both high. Read data is combinational from `reg_idx`. The reset input is asserted asynchronously, and its release is synchronised to the clock inside the unit through two flops.

Top module: `dma_wm_irq`

## Requirements
- R1: Asserting `rst_n` low clears, without waiting for a clock, every enable, every flag and every watermark address, and drives `irq` to 0.
- R2: In the control word at index 0, the enable of level n is at bit 24+n and is read/write. Bits 31:28, bits 19:16 and bits 15:0 always read as 0.
- R3: Index 1+n holds the 32-bit watermark address of level n. It is read/write.
- R4: If a clock edge sees `dma_vld` high and `dma_addr` equal to the watermark of level n, flag n (bit 20+n of the control word) reads 1 from the next cycle onward.
- R5: An address that matches a watermark while `dma_vld` is low does not set any flag.
- R6: Once a flag is set, it stays set through later cycles with no match and through repeated matches, until it is cleared.
- R7: A control-word write with bit 16+n at 1 clears flag n. A 0 in that bit leaves flag n unchanged.
- R8: If a clear of level n and a match of level n fall on the same edge, flag n ends up set. A clear of one level does not disturb a match of another level on that edge.
- R9: `irq` is 1 exactly when at least one level has both its flag and its enable at 1. A level whose enable is 0 still records matches in its flag.
- R10: Writing 1s to bits 23:20 of the control word does not change any flag.
- R11: Reads of indexes 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high during `reg_en` |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| dma_vld | input | 1 | DMA address valid strobe |
| dma_addr | input | 32 | Address currently issued by the DMA engine |
| irq | output | 1 | Combined level interrupt |

## Verification
Two functions can land on the same clock edge: a software clear written to the control word, and a DMA address match for the same level. The bench provokes this by driving a clear-bit write and a matching valid address in the same cycle. It judges the result by reading the flag back on the following cycle, where the flag must still be 1 and `irq` must be high. A second row clears one level while a different level matches, to show that the two levels are updated independently.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
  // number of watermark levels; field layout below depends on it
  localparam int NLVL = 4;

  // control word field positions (level n sits at LSB + n)
  localparam int EN_LSB  = 24;
  localparam int ST_LSB  = 20;
  localparam int CLR_LSB = 16;

  // register indexes
  localparam int IDX_CTRL = 0;
  localparam int IDX_LVL0 = 1;
endpackage

// File: rtl/wm_rst_sync.sv
module wm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/wm_cfg_regs.sv
module wm_cfg_regs
  import dwi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_sn,
  input  logic                         reg_en,
  input  logic                         reg_we,
  input  logic [IDX_W-1:0]             reg_idx,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [NLVL-1:0][ADDR_W-1:0]  lvl_addr,
  output logic [NLVL-1:0]              lvl_en,
  output logic [NLVL-1:0]              lvl_clr
);
  logic            wr_any;
  logic            ctrl_wr;
  logic [NLVL-1:0] en_q;
  logic [NLVL-1:0] en_d;

  assign wr_any  = reg_en & reg_we;
  assign ctrl_wr = wr_any & (reg_idx == IDX_W'(IDX_CTRL));

  // enable register: next-state then storage with explicit load enable
  always_comb begin
    en_d = reg_wdata[EN_LSB +: NLVL];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      en_q <= '0;
    else if (ctrl_wr) en_q <= en_d;
  end

  // clear requests are single-cycle pulses, never stored
  always_comb begin
    lvl_clr = ctrl_wr ? reg_wdata[CLR_LSB +: NLVL] : '0;
  end

  assign lvl_en = en_q;

  // one watermark address register per level
  for (genvar g = 0; g < NLVL; g++) begin : g_addr
    logic              ld;
    logic [ADDR_W-1:0] a_q;
    logic [ADDR_W-1:0] a_d;

    assign ld = wr_any & (reg_idx == IDX_W'(IDX_LVL0 + g));

    always_comb begin
      a_d = reg_wdata[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) a_q <= '0;
      else if (ld) a_q <= a_d;
    end

    assign lvl_addr[g] = a_q;
  end
endmodule

// File: rtl/wm_level_flag.sv
module wm_level_flag #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              dma_vld,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [ADDR_W-1:0] match_addr,
  input  logic              clr,
  output logic              flag
);
  logic hit;
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  assign hit     = dma_vld & (dma_addr == match_addr);
  assign flag_ce = hit | clr;

  // a match overrides a clear on the same edge
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/wm_readback.sv
module wm_readback
  import dwi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]             reg_idx,
  input  logic [NLVL-1:0][ADDR_W-1:0]  lvl_addr,
  input  logic [NLVL-1:0]              lvl_en,
  input  logic [NLVL-1:0]              lvl_flag,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_LSB +: NLVL] = lvl_en;
    ctrl_word[ST_LSB +: NLVL] = lvl_flag;
  end

  always_comb begin
    rdata = '0;
    if (reg_idx == IDX_W'(IDX_CTRL)) rdata = ctrl_word;
    for (int i = 0; i < NLVL; i++) begin
      if (reg_idx == IDX_W'(IDX_LVL0 + i)) rdata = DATA_W'(lvl_addr[i]);
    end
  end
endmodule

// File: rtl/dma_wm_irq.sv
module dma_wm_irq
  import dwi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_vld,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              irq
);
  logic                        rst_sn;
  logic [NLVL-1:0][ADDR_W-1:0] lvl_addr;
  logic [NLVL-1:0]             lvl_en;
  logic [NLVL-1:0]             lvl_clr;
  logic [NLVL-1:0]             flag;

  wm_rst_sync #(.STAGES(2)) i_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  wm_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_cfg (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .lvl_addr  (lvl_addr),
    .lvl_en    (lvl_en),
    .lvl_clr   (lvl_clr)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    wm_level_flag #(.ADDR_W(ADDR_W)) i_flag (
      .clk        (clk),
      .rst_sn     (rst_sn),
      .dma_vld    (dma_vld),
      .dma_addr   (dma_addr),
      .match_addr (lvl_addr[g]),
      .clr        (lvl_clr[g]),
      .flag       (flag[g])
    );
  end

  wm_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_rb (
    .reg_idx  (reg_idx),
    .lvl_addr (lvl_addr),
    .lvl_en   (lvl_en),
    .lvl_flag (flag),
    .rdata    (reg_rdata)
  );

  assign irq = |(flag & lvl_en);
endmodule

// File: rtl/dwi_checker.sv
module dwi_checker
  import dwi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic                        clk,
  input logic                        rst_sn,
  input logic                        reg_en,
  input logic                        reg_we,
  input logic [IDX_W-1:0]            reg_idx,
  input logic [DATA_W-1:0]           reg_wdata,
  input logic [DATA_W-1:0]           reg_rdata,
  input logic                        dma_vld,
  input logic [ADDR_W-1:0]           dma_addr,
  input logic                        irq,
  input logic [NLVL-1:0][ADDR_W-1:0] lvl_addr,
  input logic [NLVL-1:0]             lvl_en,
  input logic [NLVL-1:0]             flag
);
  logic [NLVL-1:0] clr_req;
  logic [NLVL-1:0] hit;

  always_comb begin
    for (int i = 0; i < NLVL; i++) begin
      clr_req[i] = reg_en && reg_we && (reg_idx == IDX_W'(IDX_CTRL)) && reg_wdata[CLR_LSB + i];
      hit[i]     = dma_vld && (dma_addr == lvl_addr[i]);
    end
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_prop
    // R4 and R8: a valid match always leaves the flag set
    p_set_on_match_r4: assert property (@(posedge clk) disable iff (!rst_sn)
      hit[g] |=> flag[g]);
    // R5: no valid strobe, no new flag
    p_no_set_invalid_r5: assert property (@(posedge clk) disable iff (!rst_sn)
      (!flag[g] && !dma_vld) |=> !flag[g]);
    // R6: sticky without a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_sn)
      (flag[g] && !clr_req[g]) |=> flag[g]);
    // R7: clear without a competing match empties the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_sn)
      (clr_req[g] && !hit[g]) |=> !flag[g]);
  end

  // R9: the line is only high with an enabled pending level
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> ((flag & lvl_en) != '0));

  // R2: reserved and clear fields of the control word read zero
  p_ctrl_zero_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_idx == IDX_W'(IDX_CTRL)) |-> (reg_rdata[31:28] == 4'h0 && reg_rdata[19:0] == 20'h0));
endmodule

bind dma_wm_irq dwi_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_dwi_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dma_vld   (dma_vld),
  .dma_addr  (dma_addr),
  .irq       (irq),
  .lvl_addr  (lvl_addr),
  .lvl_en    (lvl_en),
  .flag      (flag)
);

// File: tb/test_dma_wm_irq.sv
module test_dma_wm_irq;
  logic        clk;
  logic        rst_n;
  logic        reg_en;
  logic        reg_we;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dma_vld;
  logic [31:0] dma_addr;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dma_wm_irq i_dma_wm_irq (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_vld(dma_vld), .dma_addr(dma_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // row: {we, idx[2:0], wdata[31:0], vld, daddr[31:0], exp_status[3:0], exp_irq}
  localparam int NV = 20;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h0000_1000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 0  R3 lvl0 addr
    {1'b1, 3'd2, 32'h0000_2000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 1  R3
    {1'b1, 3'd3, 32'h0000_3000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 2  R3
    {1'b1, 3'd4, 32'h0000_4000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 3  R3
    {1'b1, 3'd0, 32'h0F00_0000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 4  R2 enable all
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_2000, 4'b0010, 1'b1},  // 5  R4 lvl1 match
    {1'b0, 3'd0, 32'h0, 1'b0, 32'h0000_1000, 4'b0010, 1'b1},  // 6  R5 no strobe
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_2004, 4'b0010, 1'b1},  // 7  R4 near miss
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_2000, 4'b0010, 1'b1},  // 8  R6 repeat match
    {1'b1, 3'd0, 32'h0F02_0000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 9  R7 clear lvl1
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_4000, 4'b1000, 1'b1},  // 10 R4 lvl3
    {1'b1, 3'd0, 32'h0700_0000, 1'b0, 32'h0, 4'b1000, 1'b0},  // 11 R9 mask lvl3
    {1'b1, 3'd0, 32'h0700_0000, 1'b0, 32'h0, 4'b1000, 1'b0},  // 12 R7 zero clear bits
    {1'b1, 3'd0, 32'h07F0_0000, 1'b0, 32'h0, 4'b1000, 1'b0},  // 13 R10 status write
    {1'b1, 3'd0, 32'h0F08_0000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 14 R7 clear lvl3
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_1000, 4'b0001, 1'b1},  // 15 R4 lvl0
    {1'b1, 3'd0, 32'h0F01_0000, 1'b1, 32'h0000_1000, 4'b0001, 1'b1},  // 16 R8 clear+match
    {1'b1, 3'd0, 32'h0F01_0000, 1'b0, 32'h0, 4'b0000, 1'b0},  // 17 R7
    {1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_3000, 4'b0100, 1'b1},  // 18 R4 lvl2
    {1'b1, 3'd0, 32'h0F04_0000, 1'b1, 32'h0000_1000, 4'b0001, 1'b1}   // 19 R8 other level
  };

  function automatic string row_req(int r);
    case (r)
      0, 1, 2, 3:      return "R3";
      4:               return "R2";
      5, 7, 10, 15, 18: return "R4";
      6:               return "R5";
      8:               return "R6";
      9, 12, 14, 17:   return "R7";
      11:              return "R9";
      13:              return "R10";
      default:         return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_en = 0; reg_we = 0; reg_idx = 3'd0; reg_wdata = '0;
    dma_vld = 0; dma_addr = '0;
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(string req, logic [2:0] idx, logic [31:0] exp);
    reg_idx = idx;
    #1;
    check(req, $sformatf("read idx %0d", idx), reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1", 3'd0, 32'h0);
    for (int k = 1; k <= 4; k++) rd_chk("R1", 3'(k), 32'h0);

    // table walk
    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      reg_en    = VEC[r][73];
      reg_we    = VEC[r][73];
      reg_idx   = VEC[r][72:70];
      reg_wdata = VEC[r][69:38];
      dma_vld   = VEC[r][37];
      dma_addr  = VEC[r][36:5];
      @(negedge clk);
      idle();
      #1;
      check(row_req(r), $sformatf("row %0d status", r), {28'b0, reg_rdata[23:20]}, {28'b0, VEC[r][4:1]});
      check(row_req(r), $sformatf("row %0d irq", r), {31'b0, irq}, {31'b0, VEC[r][0]});
    end

    // R3: watermark readback
    rd_chk("R3", 3'd1, 32'h0000_1000);
    rd_chk("R3", 3'd2, 32'h0000_2000);
    rd_chk("R3", 3'd3, 32'h0000_3000);
    rd_chk("R3", 3'd4, 32'h0000_4000);
    wr(3'd3, 32'hDEAD_BEEF);
    rd_chk("R3", 3'd3, 32'hDEAD_BEEF);

    // R11: unused indexes
    for (int k = 5; k <= 7; k++) rd_chk("R11", 3'(k), 32'h0);

    // R2: all-ones write: only enables stick, clears empty lvl0
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R2", 3'd0, 32'h0F00_0000);
    wr(3'd0, 32'h0500_0000);
    rd_chk("R2", 3'd0, 32'h0500_0000);

    // R1: asynchronous reset with a pending enabled level
    @(negedge clk);
    dma_vld = 1; dma_addr = 32'h0000_1000;
    @(negedge clk);
    idle();
    #1;
    check("R1", "irq before reset", {31'b0, irq}, 32'h1);
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1", "irq async reset", {31'b0, irq}, 32'h0);
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd1, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1", 3'd0, 32'h0);

    done = 1;
    finish_run();
  end
endmodule